// File: doc/BRIEF.md
# Stereo I2S Slave Audio Serial Port

This block connects user logic on the system clock to an audio codec that runs its digital audio interface as master. The codec drives one shared bit clock and two separate left/right framing clocks, one for the record (ADC) direction and one for the play (DAC) direction. All three codec clocks and the ADC data line pass through two-flop synchronizers. Edges of the bit clock are then detected on the system clock, so the whole block runs in a single clock domain. The system clock must run at least eight times faster than the bit clock.

In the record direction, the block shifts in each channel MSB first using standard I2S framing: the first data bit follows the framing-clock change by one bit-clock period. When a full left-then-right pair has arrived, both words are presented together with a one-cycle strobe. In the play direction, the block takes a left/right pair from the user at the start of every left channel and shifts it out MSB first on the falling edges of the bit clock. Samples are signed two's complement and are carried unchanged. The word length is a parameter (16, 20, 24 or 32). The default setting is 16-bit words, as used with a codec set to 32 kHz from a fixed 12 MHz master clock.

Top module: `i2s_slave_port`

## Requirements
- R1: After reset, `rec_valid_o` is 0, `dac_dat_o` is 0, and `rec_left_o` and `rec_right_o` are all zeros.
- R2: In the record direction, ADC data is sampled on rising bit-clock edges. The first rising edge that sees a new ADC framing level carries no bit of the new channel. The next WORD_W rising edges carry the word MSB first. A low framing level is the left channel and a high level is the right channel.
- R3: `rec_valid_o` is a single-cycle pulse. It fires once for each right channel that completes after a left channel, both starting at a real framing transition since reset. The pulse comes at the rising edge where the ADC framing clock returns low. It never fires before the first complete pair.
- R4: Record bits that arrive after the WORD_W-th data bit of a channel, and before the next framing transition, have no effect on the captured words.
- R5: In the play direction, `dac_dat_o` changes only after falling bit-clock edges. The WORD_W bits of a channel appear MSB first, starting one bit period after the DAC framing clock changes level. The left word is sent while the framing level is low and the right word while it is high.
- R6: Both play words are latched from `play_left_i` and `play_right_i` at the rising bit-clock edge that first sees the DAC framing clock low. Changes on those inputs later in the same frame do not alter the words sent.
- R7: `dac_dat_o` is 0 in every bit period after the last data bit of a channel until the next framing transition.
- R8: With a slot of exactly WORD_W bit periods, the LSB of each channel falls in the bit period in which the framing clock changes level. That LSB is captured and sent correctly.
- R9: Both directions work correctly when the system clock is exactly 8 times the bit-clock frequency.
- R10: `rec_left_o` and `rec_right_o` hold their values in every cycle in which `rec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the codec, shared by both directions |
| adc_lrc_i | input | 1 | Record framing clock from the codec (low = left) |
| adc_dat_i | input | 1 | Serial record data from the codec |
| dac_lrc_i | input | 1 | Play framing clock from the codec (low = left) |
| dac_dat_o | output | 1 | Serial play data to the codec |
| play_left_i | input | WORD_W | Left sample to send |
| play_right_i | input | WORD_W | Right sample to send |
| rec_left_o | output | WORD_W | Last captured left sample |
| rec_right_o | output | WORD_W | Last captured right sample |
| rec_valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The hardest situation to reach is a slot of exactly WORD_W bit periods. In that case the LSB of one channel and the framing change for the next share a single bit period, and the capture, the pair strobe and the reload of the transmit word all happen on the same detected edge. The stimulus streams back-to-back frames with no gap, so exact 16-bit slots sit next to padded slots of 17, 20 and 32 periods. Padding bits are driven high on the record line so that any leak into the words would show. Part of the stream runs at the minimum 8:1 clock ratio. The play inputs are changed two bit periods into every left channel, which tests that each pair is latched only at the start of the frame.

// File: rtl/i2s_slave_port.sv
module i2s_slave_port #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              adc_lrc_i,
  input  logic              adc_dat_i,
  input  logic              dac_lrc_i,
  output logic              dac_dat_o,
  input  logic [WORD_W-1:0] play_left_i,
  input  logic [WORD_W-1:0] play_right_i,
  output logic [WORD_W-1:0] rec_left_o,
  output logic [WORD_W-1:0] rec_right_o,
  output logic              rec_valid_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [1:0] bclk_sy, alr_sy, adat_sy, dlr_sy;
  logic       bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sy <= '0;
      alr_sy  <= '0;
      adat_sy <= '0;
      dlr_sy  <= '0;
      bclk_q  <= 1'b0;
    end else begin
      bclk_sy <= {bclk_sy[0], bclk_i};
      alr_sy  <= {alr_sy[0], adc_lrc_i};
      adat_sy <= {adat_sy[0], adc_dat_i};
      dlr_sy  <= {dlr_sy[0], dac_lrc_i};
      bclk_q  <= bclk_sy[1];
    end
  end

  logic bclk_rise, bclk_fall;
  assign bclk_rise = bclk_sy[1] & ~bclk_q;
  assign bclk_fall = ~bclk_sy[1] & bclk_q;

  // Record path
  logic              rx_lr_q, rx_live, rx_have_left;
  logic [CNT_W-1:0]  rx_cnt;
  logic [WORD_W-1:0] rx_sh, rx_left_hold, rx_sh_nx;
  logic              rx_edge;

  assign rx_edge  = bclk_rise & (alr_sy[1] != rx_lr_q);
  assign rx_sh_nx = (rx_cnt != CNT_FULL) ? {rx_sh[WORD_W-2:0], adat_sy[1]} : rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_lr_q      <= 1'b0;
      rx_live      <= 1'b0;
      rx_have_left <= 1'b0;
      rx_cnt       <= CNT_FULL;
      rx_sh        <= '0;
      rx_left_hold <= '0;
      rec_left_o   <= '0;
      rec_right_o  <= '0;
      rec_valid_o  <= 1'b0;
    end else begin
      rec_valid_o <= 1'b0;
      if (bclk_rise) begin
        rx_lr_q <= alr_sy[1];
        rx_sh   <= rx_sh_nx;
        if (rx_edge) begin
          rx_cnt  <= '0;
          rx_live <= 1'b1;
          if (!rx_lr_q) begin
            rx_have_left <= rx_live;
            if (rx_live) rx_left_hold <= rx_sh_nx;
          end else begin
            rx_have_left <= 1'b0;
            if (rx_live && rx_have_left) begin
              rec_left_o  <= rx_left_hold;
              rec_right_o <= rx_sh_nx;
              rec_valid_o <= 1'b1;
            end
          end
        end else if (rx_cnt != CNT_FULL) begin
          rx_cnt <= rx_cnt + CNT_W'(1);
        end
      end
    end
  end

  // Play path
  logic              tx_lr_q;
  logic [CNT_W-1:0]  tx_cnt;
  logic [WORD_W-1:0] tx_sh, tx_right_hold;
  logic              tx_edge;

  assign tx_edge = bclk_rise & (dlr_sy[1] != tx_lr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lr_q       <= 1'b0;
      tx_cnt        <= CNT_FULL;
      tx_sh         <= '0;
      tx_right_hold <= '0;
      dac_dat_o     <= 1'b0;
    end else begin
      if (bclk_rise) begin
        tx_lr_q <= dlr_sy[1];
        if (tx_edge) begin
          tx_cnt <= '0;
          if (!dlr_sy[1]) begin
            tx_sh         <= play_left_i;
            tx_right_hold <= play_right_i;
          end else begin
            tx_sh <= tx_right_hold;
          end
        end
      end
      if (bclk_fall) begin
        if (tx_cnt != CNT_FULL) begin
          dac_dat_o <= tx_sh[WORD_W-1];
          tx_sh     <= tx_sh << 1;
          tx_cnt    <= tx_cnt + CNT_W'(1);
        end else begin
          dac_dat_o <= 1'b0;
        end
      end
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |=> !rec_valid_o);

  assert_valid_at_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> !rx_lr_q);

  assert_rec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid_o |-> ($stable(rec_left_o) && $stable(rec_right_o)));

  assert_dac_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_dat_o) |-> $past(bclk_fall));

  assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && tx_cnt == CNT_FULL) |=> !dac_dat_o);
endmodule

// File: tb/i2s_slave_port_tb_top.sv
module i2s_slave_port_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, adc_lrc = 1'b0, adc_dat = 1'b0, dac_lrc = 1'b0;
  logic dac_dat_o;
  logic [W-1:0] play_l = '0, play_r = '0;
  logic [W-1:0] rec_left_o, rec_right_o;
  logic rec_valid_o;

  always #4 clk = ~clk;

  i2s_slave_port #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .adc_lrc_i(adc_lrc),
    .adc_dat_i(adc_dat), .dac_lrc_i(dac_lrc), .dac_dat_o(dac_dat_o),
    .play_left_i(play_l), .play_right_i(play_r),
    .rec_left_o(rec_left_o), .rec_right_o(rec_right_o), .rec_valid_o(rec_valid_o)
  );

  int checks = 0, failures = 0;
  int half = 8;
  bit finished = 1'b0, mon_on = 1'b0;
  logic adc_carry = 1'b1;
  bit lsb_pend = 1'b0;
  logic [W-1:0] dac_acc = '0;
  int dac_n = 0;
  logic [W-1:0] dac_q[$];
  string dac_tag_q[$];
  logic [2*W-1:0] adc_q[$];
  string adc_tag_q[$];
  string ctx = "";
  logic [W-1:0] last_l = '0, last_r = '0;
  bit prev_valid = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic take_bit(input logic s);
    dac_acc = {dac_acc[W-2:0], s};
    dac_n++;
    if (dac_n == W) begin
      if (dac_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = dac_q.pop_front();
        t = dac_tag_q.pop_front();
        check(dac_acc == e, t, 64'(dac_acc), 64'(e));
      end
      dac_n = 0;
    end
  endtask

  task automatic do_channel(input logic lr, input logic [W-1:0] aw, input int slot,
                            input bit coll, input bit upd,
                            input logic [W-1:0] nl, input logic [W-1:0] nr);
    for (int j = 0; j < slot; j++) begin
      logic d, s;
      if (j == 0) d = adc_carry;
      else if (j <= W) d = aw[W-j];
      else d = 1'b1;
      @(negedge clk);
      bclk = 1'b0; adc_lrc = lr; dac_lrc = lr; adc_dat = d;
      if (upd && j == 2) begin play_l = nl; play_r = nr; end
      repeat (half) @(negedge clk);
      s = dac_dat_o;
      bclk = 1'b1;
      repeat (half - 1) @(negedge clk);
      if (coll) begin
        if ((j == 0 && lsb_pend) || (j >= 1 && j <= W)) take_bit(s);
        else if (j > W) check(s == 1'b0, "R7 padding bit on play line", 64'(s), 64'(0));
      end else begin
        check(s == 1'b0, "R7 play line before first pair", 64'(s), 64'(0));
      end
    end
    adc_carry = (slot == W) ? aw[0] : 1'b1;
    lsb_pend  = coll && (slot == W);
  endtask

  task automatic frame(input logic [W-1:0] al, input logic [W-1:0] ar, input int slot,
                       input logic [W-1:0] nl, input logic [W-1:0] nr);
    ctx = (slot == W) ? " R8" : " R4";
    if (half == 4) ctx = {ctx, " R9"};
    dac_q.push_back(play_l); dac_tag_q.push_back({"R5 R6 left play word", ctx});
    dac_q.push_back(play_r); dac_tag_q.push_back({"R5 R6 right play word", ctx});
    do_channel(1'b0, al, slot, 1'b1, 1'b1, nl, nr);
    do_channel(1'b1, ar, slot, 1'b1, 1'b0, '0, '0);
    adc_q.push_back({al, ar});
    adc_tag_q.push_back({"R2 record pair", ctx});
  endtask

  always @(negedge clk) begin
    if (mon_on && !finished) begin
      if (rec_valid_o) begin
        check(!prev_valid, "R3 strobe longer than one cycle", 64'(prev_valid), 64'(0));
        if (adc_q.size() == 0) begin
          check(1'b0, "R3 strobe with no completed pair", 64'(1), 64'(0));
        end else begin
          logic [2*W-1:0] e;
          string t;
          e = adc_q.pop_front();
          t = adc_tag_q.pop_front();
          check({rec_left_o, rec_right_o} == e, t, 64'({rec_left_o, rec_right_o}), 64'(e));
        end
        last_l = rec_left_o;
        last_r = rec_right_o;
      end else if ({rec_left_o, rec_right_o} != {last_l, last_r}) begin
        check(1'b0, "R10 record outputs moved without strobe",
              64'({rec_left_o, rec_right_o}), 64'({last_l, last_r}));
      end
      prev_valid = rec_valid_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rec_valid_o == 1'b0, "R1 valid after reset", 64'(rec_valid_o), 64'(0));
    check(dac_dat_o == 1'b0, "R1 play line after reset", 64'(dac_dat_o), 64'(0));
    check(rec_left_o == '0, "R1 left after reset", 64'(rec_left_o), 64'(0));
    check(rec_right_o == '0, "R1 right after reset", 64'(rec_right_o), 64'(0));
    mon_on = 1'b1;
    play_l = 16'h1234; play_r = 16'hABCD;
    do_channel(1'b1, 16'h0000, W, 1'b0, 1'b0, '0, '0);
    adc_carry = 1'b0;
    frame(16'h8000, 16'h7FFF, 16, 16'h8001, 16'h7FFE);
    frame(16'hFFFF, 16'h0001, 16, 16'h0000, 16'hFFFF);
    frame(16'hA5A5, 16'h5A5A, 20, 16'hC3C3, 16'h3C3C);
    frame(16'h0000, 16'hFFFF, 32, 16'h8000, 16'h0001);
    frame(16'h0001, 16'h8000, 17, 16'h7FFF, 16'hFFFE);
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] a, b, c, e;
      a = 16'(k * 16'h1357) ^ 16'hA5A5;
      b = 16'(k * 16'h2E6B) ^ 16'h0F0F;
      c = 16'(k * 16'h3F1D) ^ 16'h6996;
      e = ~a;
      frame(a, b, (k % 3 == 0) ? 16 : 18 + 2 * k, c, e);
    end
    half = 4;
    frame(16'h7FFF, 16'h8000, 16, 16'h0F0F, 16'hF0F0);
    frame(16'hDEAD, 16'hBEEF, 24, 16'h1111, 16'h2222);
    frame(16'h0FF0, 16'hF00F, 16, 16'h3333, 16'h4444);
    do_channel(1'b0, 16'h0000, W, 1'b1, 1'b0, '0, '0);
    repeat (10) @(negedge clk);
    check(adc_q.size() == 0, "R3 every completed pair strobed", 64'(adc_q.size()), 64'(0));
    check(dac_q.size() == 0, "R5 every play word sent", 64'(dac_q.size()), 64'(0));
    finish_run();
  end
endmodule